// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

This block collects 32 interrupt request inputs, conditions each one according to its own trigger type, and gates each through a per-source enable. Every source carries a routing byte. The upper nibble of that byte selects which of four parent interrupt lines the source drives. The lower nibble is a mask of the processor cores that receive it. The controller produces four parent lines for each of four cores, 16 outputs in total. An output asserts while at least one pending source is routed to that core and selects that line.

Software reaches the block through a small memory-mapped port: a byte address, a 32-bit write word with per-byte write strobes, and a combinational read word. Through this port it programs the routing bytes and the polarity and edge selections. It sets enables with a write-ones-to-set register and clears them with a write-ones-to-clear register. It reads the enable state and a separate pending word for each core.

Each raw input passes through a two-flip-flop synchronizer before polarity and edge logic. A source in level mode reports pending while its conditioned level is active. A source in edge mode holds a latched flag from the qualifying edge until software disables it.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset every routing byte, enable, polarity and edge bit reads zero, every core pending word reads zero and all 16 parent outputs are low.
- R2: Source k owns the byte at address k (0 to 31). It appears in the word at address 4*(k/4), bits 8*(k%4)+7 down to 8*(k%4). Each byte lane is written only when its strobe bit is set.
- R3: A write to 0x28 sets the enable bits given as ones in the strobed lanes. A write to 0x2C clears them. Zero bits and unstrobed lanes are left unchanged. 0x24 reads back the enables and ignores writes. 0x28 and 0x2C read as zero.
- R4: 0x30 (polarity) and 0x34 (edge) are read/write, lane by lane under the strobes. For each source the (edge, polarity) pair selects the trigger: (0,0) level-high, (0,1) level-low, (1,0) rising edge, (1,1) falling edge.
- R5: A level-mode source is pending while it is enabled and its synchronized input XOR its polarity bit is 1. The input is seen two clock edges after it changes.
- R6: An enabled edge-mode source latches pending on a 0-to-1 transition of its conditioned level. It stays pending until a disable write clears its enable. Clearing its edge bit discards the latch.
- R7: A qualifying edge that falls in the same cycle as a disable write for that source is discarded. An edge that falls in the same cycle as the enable write for that source is not captured.
- R8: Core n reads at address 0x40 + 8*n a word whose bit k is source k pending AND bit n of its routing byte.
- R9: parent_irq bit 4*n+p is high exactly when some source pending for core n has bit 4+p of its routing byte set.
- R10: Reads of any address other than the routing words, 0x24, 0x30, 0x34 and the core words return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | Raw interrupt requests, asynchronous |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Per-byte write strobes; zero means no write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| parent_irq | output | 16 | Parent lines, bit 4*core+line |

## Verification
Two functions can land in the same cycle: a synchronized rising edge reaches the latch logic while a register write is also landing. One case pairs the edge with a disable write to the same source. The other pairs it with that source's enable write. The bench raises the input one negative edge before the cycle that precedes the write, so that the synchronizer output rises exactly as the write commits. It then re-enables the source, or leaves it enabled, and judges the outcome from the core pending word and the parent outputs, which must both stay clear. Random mixes of routing, trigger and enable writes against a bench model cover the ordinary paths.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NSRC        = 32;
    localparam int NPAR        = 4;
    localparam int NCORE       = 4;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam int WORD_W      = ADDR_W - 2;
    localparam int SRC_W       = $clog2(NSRC);
    localparam int CORE_W      = $clog2(NCORE);
    localparam int ROUTE_WORDS = NSRC / LANES;
    localparam int OUT_W       = NCORE * NPAR;

    // word indices (byte address divided by four)
    localparam logic [WORD_W-1:0] W_STAT  = 6'h09;
    localparam logic [WORD_W-1:0] W_ENA   = 6'h0A;
    localparam logic [WORD_W-1:0] W_DIS   = 6'h0B;
    localparam logic [WORD_W-1:0] W_POL   = 6'h0C;
    localparam logic [WORD_W-1:0] W_EDG   = 6'h0D;
    localparam logic [WORD_W-1:0] W_CORE0 = 6'h10;

    typedef struct packed {
        logic [NPAR-1:0]  line;   // one-hot parent line choice
        logic [NCORE-1:0] cores;  // destination core mask
    } route_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] strb);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < LANES; b++) m[8*b +: 8] = {8{strb[b]}};
        return m;
    endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [LANES-1:0]             wstrb,
    input  logic [NCORE-1:0][NSRC-1:0]   core_pend,
    output route_t [NSRC-1:0]            route,
    output logic [NSRC-1:0]              en,
    output logic [NSRC-1:0]              pol,
    output logic [NSRC-1:0]              edg,
    output logic [NSRC-1:0]              dis_hit,
    output logic [DATA_W-1:0]            rdata
);
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] wmask, wbits;
    logic              wr;
    logic [WORD_W-1:0] core_off;

    assign word     = addr[ADDR_W-1:2];
    assign wmask    = lane_mask(wstrb);
    assign wbits    = wdata & wmask;
    assign wr       = |wstrb;
    assign dis_hit  = (wr && word == W_DIS) ? wbits : '0;
    assign core_off = (word - W_CORE0) >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            route <= '0;
            en    <= '0;
            pol   <= '0;
            edg   <= '0;
        end else if (wr) begin
            if (word < WORD_W'(ROUTE_WORDS)) begin
                for (int b = 0; b < LANES; b++)
                    if (wstrb[b]) route[{word[SRC_W-3:0], 2'(b)}] <= wdata[8*b +: 8];
            end
            if (word == W_ENA)      en <= en | wbits;
            else if (word == W_DIS) en <= en & ~wbits;
            if (word == W_POL) pol <= (pol & ~wmask) | wbits;
            if (word == W_EDG) edg <= (edg & ~wmask) | wbits;
        end
    end

    always_comb begin
        rdata = '0;
        if (word < WORD_W'(ROUTE_WORDS)) begin
            for (int b = 0; b < LANES; b++)
                rdata[8*b +: 8] = route[{word[SRC_W-3:0], 2'(b)}];
        end else if (word == W_STAT) begin
            rdata = en;
        end else if (word == W_POL) begin
            rdata = pol;
        end else if (word == W_EDG) begin
            rdata = edg;
        end else if (word >= W_CORE0 && !word[0] && core_off < WORD_W'(NCORE)) begin
            rdata = core_pend[core_off[CORE_W-1:0]];
        end
    end
endmodule

// File: rtl/irq_router_cond.sv
module irq_router_cond
    import irq_router_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] pol,
    input  logic [NSRC-1:0] edg,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] dis_hit,
    output logic [NSRC-1:0] pending,
    output logic [NSRC-1:0] latched
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic s1, s2, lvl_d, lat, lvl;

        assign lvl = s2 ^ pol[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                s1    <= 1'b0;
                s2    <= 1'b0;
                lvl_d <= 1'b0;
                lat   <= 1'b0;
            end else begin
                s1    <= raw[i];
                s2    <= s1;
                lvl_d <= lvl;
                if (!edg[i] || dis_hit[i]) lat <= 1'b0;
                else if (en[i] && lvl && !lvl_d) lat <= 1'b1;
            end
        end

        assign pending[i] = en[i] & (edg[i] ? lat : lvl);
        assign latched[i] = lat;
    end
endmodule

// File: rtl/irq_router_fanout.sv
module irq_router_fanout
    import irq_router_pkg::*;
(
    input  route_t [NSRC-1:0]           route,
    input  logic [NSRC-1:0]             pending,
    output logic [NCORE-1:0][NSRC-1:0]  core_pend,
    output logic [OUT_W-1:0]            parent
);
    logic [NPAR-1:0][NSRC-1:0] line_sel;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            for (int n = 0; n < NCORE; n++) core_pend[n][i] = pending[i] & route[i].cores[n];
            for (int p = 0; p < NPAR; p++)  line_sel[p][i]  = route[i].line[p];
        end
    end

    for (genvar n = 0; n < NCORE; n++) begin : g_core
        for (genvar p = 0; p < NPAR; p++) begin : g_line
            assign parent[n*NPAR + p] = |(core_pend[n] & line_sel[p]);
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]   bus_wstrb,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [OUT_W-1:0]   parent_irq
);
    route_t [NSRC-1:0]          route_w;
    logic [NSRC-1:0]            en_w, pol_w, edg_w, dis_w, pend_w, lat_w;
    logic [NCORE-1:0][NSRC-1:0] core_pend_w;

    irq_router_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .wstrb(bus_wstrb),
        .core_pend(core_pend_w), .route(route_w), .en(en_w), .pol(pol_w), .edg(edg_w),
        .dis_hit(dis_w), .rdata(bus_rdata)
    );

    irq_router_cond u_cond (
        .clk(clk), .rst(rst), .raw(irq_in), .pol(pol_w), .edg(edg_w), .en(en_w),
        .dis_hit(dis_w), .pending(pend_w), .latched(lat_w)
    );

    irq_router_fanout u_fan (
        .route(route_w), .pending(pend_w), .core_pend(core_pend_w), .parent(parent_irq)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [LANES-1:0]      bus_wstrb,
    input logic [NSRC-1:0]       en_q,
    input logic [NSRC-1:0]       pol_q,
    input logic [NSRC-1:0]       edg_q,
    input logic [NSRC-1:0]       lat_q,
    input logic [NSRC*8-1:0]     route_q,
    input logic [OUT_W-1:0]      parent_irq
);
    logic [WORD_W-1:0] w;
    logic full_ena, full_dis, stray_wr;
    assign w        = bus_addr[ADDR_W-1:2];
    assign full_ena = (bus_wstrb == '1) && (w == W_ENA);
    assign full_dis = (bus_wstrb == '1) && (w == W_DIS);
    assign stray_wr = (|bus_wstrb) && !(w < WORD_W'(ROUTE_WORDS)) &&
                      w != W_ENA && w != W_DIS && w != W_POL && w != W_EDG;

    a_r3_enable_sets: assert property (@(posedge clk) disable iff (rst)
        full_ena |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
        full_dis |=> ((en_q & $past(bus_wdata)) == '0));

    a_r7_disable_beats_edge: assert property (@(posedge clk) disable iff (rst)
        full_dis |=> ((lat_q & $past(bus_wdata)) == '0));

    a_r6_latch_only_enabled: assert property (@(posedge clk) disable iff (rst)
        ((lat_q & ~en_q) == '0));

    a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (parent_irq == '0));

    a_r10_stray_write_ignored: assert property (@(posedge clk) disable iff (rst)
        stray_wr |=> ($stable(en_q) && $stable(pol_q) && $stable(edg_q) && $stable(route_q)));
endmodule

bind irq_router irq_router_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .en_q(en_w), .pol_q(pol_w), .edg_q(edg_w), .lat_q(lat_w), .route_q(route_w),
    .parent_irq(parent_irq)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
    import irq_router_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   irq_in = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [LANES-1:0]  bus_wstrb = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [OUT_W-1:0]  parent_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [7:0]      m_route [NSRC];
    logic [NSRC-1:0] m_en, m_pol, m_edg, m_lat, m_in;

    irq_router u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata), .parent_irq(parent_irq)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wstrb = '0; bus_addr = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        irq_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NSRC; i++) m_route[i] = '0;
        m_en = '0; m_pol = '0; m_edg = '0; m_lat = '0; m_in = '0;
    endtask

    function automatic logic [31:0] exp_pend();
        return m_en & ((m_edg & m_lat) | (~m_edg & (m_in ^ m_pol)));
    endfunction

    function automatic logic [31:0] exp_core(input int n);
        logic [31:0] p, r;
        p = exp_pend();
        for (int i = 0; i < NSRC; i++) r[i] = p[i] & m_route[i][n];
        return r;
    endfunction

    function automatic logic [15:0] exp_parent();
        logic [15:0] o;
        o = '0;
        for (int n = 0; n < NCORE; n++) begin
            logic [31:0] c;
            c = exp_core(n);
            for (int i = 0; i < NSRC; i++)
                for (int p = 0; p < NPAR; p++)
                    if (c[i] && m_route[i][4+p]) o[n*NPAR+p] = 1'b1;
        end
        return o;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        bus_read(8'h24, d); chk({tag, " R3 status"}, d, m_en);
        bus_read(8'h30, d); chk({tag, " R4 pol"}, d, m_pol);
        bus_read(8'h34, d); chk({tag, " R4 edge"}, d, m_edg);
        for (int n = 0; n < NCORE; n++) begin
            bus_read(8'h40 + 8'(8*n), d);
            chk({tag, " R8 core"}, d, exp_core(n));
        end
        for (int k = 0; k < ROUTE_WORDS; k++) begin
            bus_read(8'(4*k), d);
            chk({tag, " R2 route"}, d, {m_route[4*k+3], m_route[4*k+2], m_route[4*k+1], m_route[4*k]});
        end
        @(negedge clk);
        chk({tag, " R9 parent"}, {16'h0, parent_irq}, {16'h0, exp_parent()});
    endtask

    // one random operation, applied to DUT and model
    task automatic rand_op();
        int op;
        logic [31:0] d, m, c_old, c_new;
        logic [3:0] s;
        op = $urandom_range(0, 6);
        d  = $urandom();
        s  = 4'($urandom_range(1, 15));
        m  = lane_mask(s);
        c_old = m_in ^ m_pol;
        case (op)
            0: begin
                int k;
                k = $urandom_range(0, ROUTE_WORDS-1);
                bus_write(8'(4*k), d, s);
                for (int b = 0; b < 4; b++) if (s[b]) m_route[4*k+b] = d[8*b +: 8];
            end
            1: begin bus_write(8'h28, d, s); m_en = m_en | (d & m); end
            2: begin bus_write(8'h2C, d, s); m_en = m_en & ~(d & m); m_lat = m_lat & ~(d & m); end
            3: begin
                bus_write(8'h30, d, s);
                m_pol = (m_pol & ~m) | (d & m);
                c_new = m_in ^ m_pol;
                m_lat = m_lat | (m_en & m_edg & c_new & ~c_old);
            end
            4: begin
                bus_write(8'h34, d, s);
                m_edg = (m_edg & ~m) | (d & m);
                m_lat = m_lat & m_edg;
            end
            default: begin
                @(negedge clk);
                irq_in = d;
                m_in = d;
                c_new = m_in ^ m_pol;
                m_lat = m_lat | (m_en & m_edg & c_new & ~c_old);
            end
        endcase
        settle();
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));

        // R1: reset state
        do_reset();
        settle();
        check_all("R1 reset");

        // directed: source 5, line 1, core 0, rising edge
        bus_write(8'h04, 32'h0000_2100, 4'b0010);
        bus_write(8'h34, 32'h0000_0020, 4'hF);
        bus_write(8'h28, 32'h0000_0020, 4'hF);
        settle();
        bus_read(8'h04, d); chk("R2 byte lane write", d, 32'h0000_2100);

        // R7: edge lands in the cycle of a disable write
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk);
        bus_write(8'h2C, 32'h0000_0020, 4'hF);
        bus_write(8'h28, 32'h0000_0020, 4'hF);
        settle();
        bus_read(8'h40, d); chk("R7 disable beats edge", d, 32'h0);
        chk("R7 parent after disable race", {16'h0, parent_irq}, 32'h0);

        // R6: fresh edge latches and holds
        @(negedge clk); irq_in[5] = 1'b0;
        settle();
        @(negedge clk); irq_in[5] = 1'b1;
        settle();
        bus_read(8'h40, d); chk("R6 rising edge latched", d, 32'h0000_0020);
        chk("R9 parent core0 line1", {16'h0, parent_irq}, 32'h0000_0002);
        @(negedge clk); irq_in[5] = 1'b0;
        settle();
        bus_read(8'h40, d); chk("R6 latch holds after input drops", d, 32'h0000_0020);
        bus_read(8'h48, d); chk("R8 core1 not routed", d, 32'h0);

        // R6: disable clears
        bus_write(8'h2C, 32'h0000_0020, 4'hF);
        settle();
        bus_read(8'h40, d); chk("R6 disable clears latch", d, 32'h0);

        // R7: edge lands in the cycle of the enable write
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk);
        bus_write(8'h28, 32'h0000_0020, 4'hF);
        settle();
        bus_read(8'h40, d); chk("R7 edge during enable write not captured", d, 32'h0);

        // R4: falling edge mode
        bus_write(8'h30, 32'h0000_0020, 4'b0001);
        settle();
        bus_read(8'h40, d); chk("R4 polarity flip no falling edge yet", d, 32'h0);
        @(negedge clk); irq_in[5] = 1'b0;
        settle();
        bus_read(8'h40, d); chk("R4 falling edge latched", d, 32'h0000_0020);
        @(negedge clk); irq_in[5] = 1'b1;
        settle();
        bus_write(8'h34, 32'h0, 4'hF);
        settle();
        bus_read(8'h40, d); chk("R6 leaving edge mode drops latch (level-low, input high)", d, 32'h0);
        @(negedge clk); irq_in[5] = 1'b0;
        settle();
        bus_read(8'h40, d); chk("R5 level-low pending", d, 32'h0000_0020);

        // R5: input seen after two edges, not after one
        bus_write(8'h30, 32'h0, 4'hF);
        settle();
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk);
        #1 chk("R5 one edge not yet visible", {16'h0, parent_irq}, 32'h0);
        @(negedge clk);
        #1 chk("R5 visible after two edges", {16'h0, parent_irq}, 32'h0000_0002);

        // R10: stray addresses
        bus_write(8'h20, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'h3C, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'h44, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'h24, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'h80, 32'hFFFF_FFFF, 4'hF);
        bus_read(8'h24, d); chk("R10 enables unchanged", d, 32'h0000_0020);
        bus_read(8'h34, d); chk("R10 edge unchanged", d, 32'h0);
        bus_read(8'h00, d); chk("R10 route word0 unchanged", d, 32'h0);
        bus_read(8'h3C, d); chk("R10 stray read zero", d, 32'h0);
        bus_read(8'h60, d); chk("R10 beyond cores read zero", d, 32'h0);
        bus_read(8'h28, d); chk("R3 enable reg reads zero", d, 32'h0);
        bus_read(8'h2C, d); chk("R3 disable reg reads zero", d, 32'h0);

        // random phase against the model
        do_reset();
        for (int r = 0; r < 300; r++) begin
            rand_op();
            if (r % 10 == 9) check_all("rand");
        end
        check_all("final");

        finish_run();
    end
endmodule